// File: doc/BRIEF.md
# AUX Reply Status Classifier with Retry Sequencer

This block sits behind an auxiliary-channel transfer engine. For each attempt it starts the engine, waits for the done indication, and sorts the engine's status flags and receive buffer into one result code. It also pulls out a 4-bit reply code and, when the reply is an acknowledge, the received data bytes. A sequencer around the decoder reissues failed attempts after a fixed idle gap. It stops at the first attempt that ends with a good result and an acknowledge, or after the last permitted attempt.

The sequencer has six states. S_IDLE waits for `start`. S_ISSUE drives `launch` for one cycle. S_WAIT waits for `done` or for the timeout window to run out. S_DECIDE shows the captured result on `res_valid`. S_GAP counts the inter-attempt idle time. S_FINISH pulses `xfer_done`. The transitions are:
- start: S_IDLE to S_ISSUE.
- issue: S_ISSUE to S_WAIT.
- capture: S_WAIT to S_DECIDE, taken on `done` or on window expiry.
- success: S_DECIDE to S_FINISH.
- exhausted: S_DECIDE to S_FINISH.
- retry: S_DECIDE to S_GAP.
- relaunch: S_GAP to S_ISSUE.
- close: S_FINISH to S_IDLE.

Result encoding: 0 OK, 1 DISCONNECT, 2 TIMEOUT, 3 INVALID, 4 OVERFLOW.

Top module: `auxrep_seq`

## Requirements
- R1: After reset the block sits idle. `launch`, `busy`, `res_valid`, `xfer_done`, `xfer_ok` and `xfer_fail` are 0. `result` is 0, `reply_code` is 0 and `data_count` is 0.
- R2: When `done` is sampled with `hpd_lost` high, the result is 1 (DISCONNECT) whatever the other flags say.
- R3: With no disconnect, either `tmo_state` or `tmo_flag` gives result 2 (TIMEOUT), even if receive error flags are also set.
- R4: With no disconnect or timeout, any of `err_stop`, `err_nodet`, `err_high` or `err_low` gives result 3 (INVALID). `err_mincnt` never changes the result.
- R5: A replied count of 0 gives result 3 (INVALID). Otherwise, on an acknowledge, `data_count` equals `rx_count` minus 1.
- R6: `reply_code` is bits [7:4] of receive byte 0 (`rx_bytes[7:4]`); code 0 is the acknowledge. Data is delivered only on acknowledge. For any other code, `data_count` is 0 and `data_out` is all zero. On acknowledge, `data_out` byte i equals receive byte i+1 for i below `data_count`, and is zero above.
- R7: On acknowledge, if `rx_count` minus 1 exceeds `buf_size`, the result is 4 (OVERFLOW) and `data_count` is 0.
- R8: If `done` has not arrived after `tmo_limit` wait cycles, the attempt ends with result 2. `res_valid` then rises exactly `tmo_limit`+1 cycles after the `launch` cycle.
- R9: A transfer makes at most 7 attempts. It stops after the first attempt whose result is 0 with reply code 0. Each retry `launch` comes exactly GAP_CYC+1 cycles after the `res_valid` cycle of the failed attempt.
- R10: `xfer_done` pulses for one cycle at the end of the transfer. `xfer_ok` is 1 after success. `xfer_fail` is 1 when all 7 attempts ended without success. Exactly one of them is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken in idle) |
| buf_size | input | CNT_W | Caller buffer capacity in bytes |
| tmo_limit | input | TMO_W | Wait window in cycles (at least 1) |
| done | input | 1 | Engine finished the attempt |
| hpd_lost | input | 1 | Hot-plug disconnect flag |
| tmo_state | input | 1 | Receive timeout-state flag |
| tmo_flag | input | 1 | Receive timeout flag |
| err_stop | input | 1 | Invalid stop condition |
| err_nodet | input | 1 | Reply not detected |
| err_high | input | 1 | Invalid high symbol |
| err_low | input | 1 | Invalid low symbol |
| err_mincnt | input | 1 | Minimum-count violation (ignored) |
| rx_count | input | CNT_W | Bytes replied, including byte 0 |
| rx_bytes | input | MAX_BYTES*8 | Receive buffer, byte 0 in bits [7:0] |
| launch | output | 1 | One-cycle attempt start to the engine |
| busy | output | 1 | Transfer in progress |
| res_valid | output | 1 | Per-attempt result is valid this cycle |
| result | output | 3 | Result code of the last attempt |
| reply_code | output | 4 | Reply nibble of the last attempt |
| data_count | output | CNT_W | Delivered data bytes |
| data_out | output | (MAX_BYTES-1)*8 | Delivered data, byte 0 in bits [7:0] |
| xfer_done | output | 1 | Transfer finished (pulse) |
| xfer_ok | output | 1 | Transfer ended with acknowledge |
| xfer_fail | output | 1 | All attempts failed |

## Verification
The decoder is driven with stacked flag patterns: disconnect with timeout and errors, timeout with errors, and a single error flag. These tell the priority levels apart. A lone minimum-count flag shows that flag has no effect. Replies of count 0, count 1 and count 5 separate the invalid case from an empty acknowledge and from delivered data. A count larger than the buffer isolates the overflow result. Negative-acknowledge and defer replies exercise the retry loop: a run of seven failures shows the attempt cap, and a reply that turns good on attempt three shows the early stop. A silent engine checks the exact cycle at which the timeout window expires, and the launch-to-launch spacing checks the gap.

// File: rtl/auxrep_pkg.sv
package auxrep_pkg;
    typedef enum logic [2:0] {
        RES_OK   = 3'd0,
        RES_DISC = 3'd1,
        RES_TMO  = 3'd2,
        RES_INV  = 3'd3,
        RES_OVF  = 3'd4
    } res_e;

    typedef enum logic [2:0] {
        S_IDLE, S_ISSUE, S_WAIT, S_DECIDE, S_GAP, S_FINISH
    } state_e;
endpackage

// File: rtl/auxrep_decode.sv
module auxrep_decode
    import auxrep_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             hpd,
    input  logic             tmo_any,
    input  logic [3:0]       rx_err,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] buf_size,
    input  logic [3:0]       hi_nib,
    output res_e             res,
    output logic [3:0]       reply,
    output logic [CNT_W-1:0] dcount
);
    logic [CNT_W-1:0] payload;
    assign payload = rx_count - CNT_W'(1);

    always_comb begin
        res    = RES_OK;
        reply  = 4'd0;
        dcount = '0;
        if (hpd) begin
            res = RES_DISC;
        end else if (tmo_any) begin
            res = RES_TMO;
        end else if (|rx_err) begin
            res = RES_INV;
        end else if (rx_count == '0) begin
            res = RES_INV;
        end else begin
            reply = hi_nib;
            if (hi_nib == 4'd0) begin
                if (payload > buf_size) res = RES_OVF;
                else                    dcount = payload;
            end
        end
    end
endmodule

// File: rtl/auxrep_unpack.sv
module auxrep_unpack #(
    parameter int NB    = 16,
    parameter int CNT_W = 5
) (
    input  logic [NB*8-1:0]  raw,
    input  logic [CNT_W-1:0] dcount,
    output logic [NB*8-1:0]  data
);
    for (genvar g = 0; g < NB; g++) begin : g_byte
        assign data[g*8 +: 8] = (CNT_W'(g) < dcount) ? raw[g*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/auxrep_seq.sv
module auxrep_seq
    import auxrep_pkg::*;
#(
    parameter int MAX_BYTES = 17,
    parameter int TMO_W     = 16,
    parameter int RETRIES   = 7,
    parameter int GAP_CYC   = 8,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1),
    localparam int NB       = MAX_BYTES - 1,
    localparam int ATT_W    = $clog2(RETRIES + 1),
    localparam int GAP_W    = $clog2(GAP_CYC + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [CNT_W-1:0]       buf_size,
    input  logic [TMO_W-1:0]       tmo_limit,
    input  logic                   done,
    input  logic                   hpd_lost,
    input  logic                   tmo_state,
    input  logic                   tmo_flag,
    input  logic                   err_stop,
    input  logic                   err_nodet,
    input  logic                   err_high,
    input  logic                   err_low,
    input  logic                   err_mincnt,
    input  logic [CNT_W-1:0]       rx_count,
    input  logic [MAX_BYTES*8-1:0] rx_bytes,
    output logic                   launch,
    output logic                   busy,
    output logic                   res_valid,
    output logic [2:0]             result,
    output logic [3:0]             reply_code,
    output logic [CNT_W-1:0]       data_count,
    output logic [NB*8-1:0]        data_out,
    output logic                   xfer_done,
    output logic                   xfer_ok,
    output logic                   xfer_fail
);
    state_e           st, st_n;
    logic [TMO_W-1:0] timer;
    logic [GAP_W-1:0] gap_cnt;
    logic [ATT_W-1:0] att_cnt;
    logic             in_wait, expire, capture, success, last_try;

    res_e             dec_res;
    logic [3:0]       dec_reply;
    logic [CNT_W-1:0] dec_count;
    logic [NB*8-1:0]  dec_data;
    res_e             res_q;

    // The minimum-count flag is deliberately not routed into the decoder.
    auxrep_decode #(.CNT_W(CNT_W)) u_decode (
        .hpd      (hpd_lost),
        .tmo_any  (tmo_state | tmo_flag),
        .rx_err   ({err_stop, err_nodet, err_high, err_low}),
        .rx_count (rx_count),
        .buf_size (buf_size),
        .hi_nib   (rx_bytes[7:4]),
        .res      (dec_res),
        .reply    (dec_reply),
        .dcount   (dec_count)
    );

    auxrep_unpack #(.NB(NB), .CNT_W(CNT_W)) u_unpack (
        .raw    (rx_bytes[MAX_BYTES*8-1:8]),
        .dcount (dec_count),
        .data   (dec_data)
    );

    assign in_wait  = (st == S_WAIT);
    assign expire   = in_wait && !done && (timer == tmo_limit);
    assign capture  = in_wait && (done || expire);
    assign success  = (res_q == RES_OK) && (reply_code == 4'd0);
    assign last_try = (att_cnt == ATT_W'(RETRIES - 1));

    always_comb begin
        st_n = st;
        unique case (st)
            S_IDLE:   if (start) st_n = S_ISSUE;
            S_ISSUE:  st_n = S_WAIT;
            S_WAIT:   if (capture) st_n = S_DECIDE;
            S_DECIDE: st_n = (success || last_try) ? S_FINISH : S_GAP;
            S_GAP:    if (gap_cnt == GAP_W'(GAP_CYC - 1)) st_n = S_ISSUE;
            S_FINISH: st_n = S_IDLE;
            default:  st_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer      <= '0;
            gap_cnt    <= '0;
            att_cnt    <= '0;
            res_q      <= RES_OK;
            reply_code <= 4'd0;
            data_count <= '0;
            data_out   <= '0;
            xfer_ok    <= 1'b0;
            xfer_fail  <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (start) begin
                        att_cnt   <= '0;
                        xfer_ok   <= 1'b0;
                        xfer_fail <= 1'b0;
                    end
                end
                S_ISSUE: begin
                    timer <= TMO_W'(1);
                end
                S_WAIT: begin
                    timer <= timer + TMO_W'(1);
                    if (done) begin
                        res_q      <= dec_res;
                        reply_code <= dec_reply;
                        data_count <= dec_count;
                        data_out   <= dec_data;
                    end else if (expire) begin
                        res_q      <= RES_TMO;
                        reply_code <= 4'd0;
                        data_count <= '0;
                        data_out   <= '0;
                    end
                end
                S_DECIDE: begin
                    gap_cnt <= '0;
                    if (success)       xfer_ok   <= 1'b1;
                    else if (last_try) xfer_fail <= 1'b1;
                end
                S_GAP: begin
                    gap_cnt <= gap_cnt + GAP_W'(1);
                    if (gap_cnt == GAP_W'(GAP_CYC - 1)) att_cnt <= att_cnt + ATT_W'(1);
                end
                S_FINISH: begin
                end
                default: begin
                end
            endcase
        end
    end

    assign result    = res_q;
    assign launch    = (st == S_ISSUE);
    assign busy      = (st != S_IDLE);
    assign res_valid = (st == S_DECIDE);
    assign xfer_done = (st == S_FINISH);
endmodule

// File: rtl/auxrep_chk.sv
module auxrep_chk #(
    parameter int CNT_W   = 5,
    parameter int RETRIES = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             in_wait,
    input logic             done,
    input logic             hpd_lost,
    input logic             tmo_any,
    input logic             err_any,
    input logic [CNT_W-1:0] rx_count,
    input logic             launch,
    input logic             res_valid,
    input logic [2:0]       result,
    input logic [3:0]       reply_code,
    input logic [CNT_W-1:0] data_count,
    input logic             xfer_done,
    input logic             xfer_ok,
    input logic             xfer_fail
);
    logic [7:0] launches;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              launches <= '0;
        else if (start && !busy) launches <= '0;
        else if (launch)         launches <= launches + 8'd1;
    end

    // R2
    hpd_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait && done && hpd_lost |=> res_valid && result == 3'd1);

    // R3
    tmo_over_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait && done && !hpd_lost && tmo_any |=> result == 3'd2);

    // R4
    mincnt_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait && done && !hpd_lost && !tmo_any && !err_any && rx_count != '0
        |=> result != 3'd3);

    // R6
    nak_nodata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && reply_code != 4'd0 |-> data_count == '0);

    // R9
    attempt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launches <= 8'(RETRIES));

    // R10
    end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (xfer_ok != xfer_fail));

    // R10
    ok_is_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done && xfer_ok |-> result == 3'd0 && reply_code == 4'd0);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);
endmodule

bind auxrep_seq auxrep_chk #(.CNT_W(CNT_W), .RETRIES(RETRIES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .in_wait    (in_wait),
    .done       (done),
    .hpd_lost   (hpd_lost),
    .tmo_any    (tmo_state | tmo_flag),
    .err_any    (err_stop | err_nodet | err_high | err_low),
    .rx_count   (rx_count),
    .launch     (launch),
    .res_valid  (res_valid),
    .result     (result),
    .reply_code (reply_code),
    .data_count (data_count),
    .xfer_done  (xfer_done),
    .xfer_ok    (xfer_ok),
    .xfer_fail  (xfer_fail)
);

// File: tb/auxrep_seq_bench.sv
module auxrep_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAXB  = 17;
    localparam int CW    = 5;
    localparam int NB    = MAXB - 1;
    localparam int GAP   = 8;
    localparam int TLIM  = 20;

    logic clk = 0, rst_n = 0, start = 0;
    logic [CW-1:0] buf_size = 5'd16;
    logic [15:0] tmo_limit = 16'(TLIM);
    logic done = 0, hpd_lost = 0, tmo_state = 0, tmo_flag = 0;
    logic err_stop = 0, err_nodet = 0, err_high = 0, err_low = 0, err_mincnt = 0;
    logic [CW-1:0] rx_count = 0;
    logic [MAXB*8-1:0] rx_bytes = 0;
    logic launch, busy, res_valid, xfer_done, xfer_ok, xfer_fail;
    logic [2:0] result;
    logic [3:0] reply_code;
    logic [CW-1:0] data_count;
    logic [NB*8-1:0] data_out;

    auxrep_seq #(.MAX_BYTES(MAXB), .TMO_W(16), .RETRIES(7), .GAP_CYC(GAP)) u_auxrep_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .buf_size(buf_size), .tmo_limit(tmo_limit),
        .done(done), .hpd_lost(hpd_lost), .tmo_state(tmo_state), .tmo_flag(tmo_flag),
        .err_stop(err_stop), .err_nodet(err_nodet), .err_high(err_high), .err_low(err_low),
        .err_mincnt(err_mincnt), .rx_count(rx_count), .rx_bytes(rx_bytes),
        .launch(launch), .busy(busy), .res_valid(res_valid), .result(result),
        .reply_code(reply_code), .data_count(data_count), .data_out(data_out),
        .xfer_done(xfer_done), .xfer_ok(xfer_ok), .xfer_fail(xfer_fail));

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0, checks = 0, cyc = 0;
    bit finished = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // per-attempt engine response: {hpd, tmo_state, tmo_flag, stop, nodet, high, low, mincnt}
    logic [7:0] r_flags [7];
    int         r_count [7];
    logic [7:0] r_b0    [7];
    int         r_dly   [7];   // negative: engine never answers
    int eng_idx = 0, n_launch = 0, n_res = 0;
    int launch_cyc [8];
    int res_cyc [8];
    logic [2:0] res_code [8];
    logic [3:0] res_reply [8];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_rsp(input int i, input logic [7:0] f, input int cnt, input logic [7:0] b0, input int dly);
        r_flags[i] = f; r_count[i] = cnt; r_b0[i] = b0; r_dly[i] = dly;
    endtask

    task automatic fill(input int cnt, input logic [7:0] b0);
        for (int i = 0; i < 7; i++) set_rsp(i, 8'h00, cnt, b0, 2);
    endtask

    // engine model
    initial begin
        for (int j = 1; j < MAXB; j++) rx_bytes[j*8 +: 8] = 8'(8'h10 + j);
        forever begin
            @(negedge clk);
            if (launch) begin
                automatic int k = eng_idx;
                eng_idx++;
                if (r_dly[k] >= 0) begin
                    repeat (r_dly[k]) @(negedge clk);
                    {hpd_lost, tmo_state, tmo_flag, err_stop, err_nodet, err_high, err_low, err_mincnt} = r_flags[k];
                    rx_count = CW'(r_count[k]);
                    rx_bytes[7:0] = r_b0[k];
                    done = 1;
                    @(negedge clk);
                    done = 0;
                end
            end
        end
    end

    // recorder
    always @(negedge clk) begin
        if (launch && n_launch < 8) begin launch_cyc[n_launch] = cyc; n_launch++; end
        if (res_valid && n_res < 8) begin
            res_cyc[n_res] = cyc; res_code[n_res] = result; res_reply[n_res] = reply_code; n_res++;
        end
    end

    task automatic run_xfer();
        eng_idx = 0; n_launch = 0; n_res = 0;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        for (int w = 0; w < 2000 && !xfer_done; w++) @(negedge clk);
        chk(xfer_done == 1, "R10 xfer_done seen", xfer_done, 1);
    endtask

    task automatic t_reset();
        chk(!launch && !busy && !res_valid, "R1 idle strobes", {launch, busy, res_valid}, 0);
        chk(!xfer_done && !xfer_ok && !xfer_fail, "R1 end flags", {xfer_done, xfer_ok, xfer_fail}, 0);
        chk(result == 0 && reply_code == 0 && data_count == 0, "R1 result regs", result, 0);
    endtask

    task automatic t_ack_read();
        fill(5, 8'h00);
        run_xfer();
        chk(n_launch == 1, "R9 single attempt on ack", n_launch, 1);
        chk(xfer_ok && !xfer_fail, "R10 ok flag", xfer_ok, 1);
        chk(data_count == 4, "R5 data count", data_count, 4);
        for (int i = 0; i < 4; i++)
            chk(data_out[i*8 +: 8] == 8'(8'h11 + i), "R6 data byte", data_out[i*8 +: 8], 8'h11 + i);
        chk(data_out[4*8 +: 8] == 0, "R6 byte above count zero", data_out[4*8 +: 8], 0);
    endtask

    task automatic t_priority();
        fill(3, 8'h00);
        set_rsp(0, 8'b1111_1111, 3, 8'h00, 2);
        set_rsp(1, 8'b0101_1110, 3, 8'h00, 2);
        set_rsp(2, 8'b0000_0010, 3, 8'h00, 2);
        set_rsp(3, 8'b0000_0001, 2, 8'h00, 2);
        run_xfer();
        chk(res_code[0] == 1, "R2 disconnect wins", res_code[0], 1);
        chk(res_code[1] == 2, "R3 timeout over errors", res_code[1], 2);
        chk(res_code[2] == 3, "R4 low error invalid", res_code[2], 3);
        chk(res_code[3] == 0, "R4 mincnt ignored", res_code[3], 0);
        chk(n_launch == 4 && xfer_ok, "R9 stop at first ack", n_launch, 4);
    endtask

    task automatic t_zero();
        fill(1, 8'h00);
        set_rsp(0, 8'h00, 0, 8'h00, 2);
        run_xfer();
        chk(res_code[0] == 3, "R5 zero count invalid", res_code[0], 3);
        chk(xfer_ok && data_count == 0, "R5 count one gives no data", data_count, 0);
    endtask

    task automatic t_nack_all();
        fill(3, 8'h10);
        run_xfer();
        chk(n_launch == 7, "R9 seven attempts", n_launch, 7);
        chk(xfer_fail && !xfer_ok, "R10 final failure", xfer_fail, 1);
        chk(result == 0 && reply_code == 1, "R6 nack code", reply_code, 1);
        chk(data_count == 0 && data_out == '0, "R6 no data on nack", data_count, 0);
        for (int i = 0; i < 6; i++)
            chk(launch_cyc[i+1] - res_cyc[i] == GAP + 1, "R9 retry gap", launch_cyc[i+1] - res_cyc[i], GAP + 1);
    endtask

    task automatic t_overflow();
        buf_size = 5'd2;
        fill(3, 8'h00);
        set_rsp(0, 8'h00, 5, 8'h00, 2);
        run_xfer();
        chk(res_code[0] == 4, "R7 overflow result", res_code[0], 4);
        chk(xfer_ok && data_count == 2, "R7 fits after retry", data_count, 2);
        buf_size = 5'd16;
    endtask

    task automatic t_timeout();
        fill(2, 8'h00);
        set_rsp(0, 8'h00, 2, 8'h00, -1);
        run_xfer();
        chk(res_code[0] == 2, "R8 no done gives timeout", res_code[0], 2);
        chk(res_cyc[0] - launch_cyc[0] == TLIM + 1, "R8 window length", res_cyc[0] - launch_cyc[0], TLIM + 1);
        chk(xfer_ok && n_launch == 2, "R8 recovers next attempt", n_launch, 2);
    endtask

    task automatic t_defer();
        fill(2, 8'h20);
        set_rsp(2, 8'h00, 2, 8'h00, 3);
        run_xfer();
        chk(res_reply[0] == 2 && res_reply[1] == 2, "R6 defer code", res_reply[0], 2);
        chk(n_launch == 3 && xfer_ok, "R9 success on third", n_launch, 3);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        summary();
    end

    initial begin
        fill(3, 8'h00);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_ack_read();
        t_priority();
        t_zero();
        t_nack_all();
        t_overflow();
        t_timeout();
        t_defer();
        repeat (3) @(negedge clk);
        summary();
    end
endmodule